// File: doc/BRIEF.md
# Wrapped Burst Shaper with Lane Masking

This block sits between a memory request queue and an SDRAM data path. It takes one request at a time: a starting double-word offset, a size in double words, a byte-enable vector covering the whole burst window, a read/write flag, an ECC-enable and a bus-width select. It always turns the request into a full-length burst. A burst holds `DW_PER_BURST` double words (default 4). On the 64-bit bus each double word takes one beat. On the 32-bit bus each double word takes two beats, low half first. The double-word order wraps around the burst window, starting at the requested offset.

For every beat the block emits the double-word index, the half select, a 9-bit lane mask (high = lane not written) and a last marker. Beats outside the requested range are fully masked. When ECC is on and a write does not cover whole double words, the block raises a read-modify-write flag on the burst instead of issuing a masked write. A request whose offset and size do not fit inside the window is rejected with a one-cycle illegal pulse, and no beats follow it.

The request side and the beat side are valid/ready. Back-pressure: a beat stays on the outputs, unchanged, until `beat_ready` is high at a clock edge. `req_ready` is high only while no burst is outstanding. ECC enable and bus width are sampled together with the request.

Top module: `ddr_burst_shaper`

## Requirements
- R1: A legal request yields exactly `DW_PER_BURST` beats when `bus_wide`=1 and twice that when `bus_wide`=0, whatever its size. `beat_last` is high on the final beat only.
- R2: Beat k of a burst carries `beat_dw` = (offset + k) mod `DW_PER_BURST` on the wide bus. On the narrow bus it carries (offset + k/2) mod `DW_PER_BURST`, with `beat_half` = k mod 2 (0 = byte lanes 0..3 of the double word, 1 = lanes 4..7).
- R3: A request is legal when 1 <= size and offset + size <= `DW_PER_BURST`. An illegal request is accepted, `req_illegal` is high for exactly the one cycle after acceptance, no beat is issued, and `req_ready` remains high.
- R4: In a write burst without read-modify-write, a beat whose position k (wide) or k/2 (narrow) is not below size has `beat_mask` = 9'h1FF.
- R5: With ECC off, a requested write beat on the wide bus has `beat_mask[7:0]` equal to the inverted byte enables `req_be[8*dw+7 : 8*dw]` and `beat_mask[8]` (the ECC lane) = 1.
- R6: With ECC on and all byte enables set in every requested double word, `beat_rmw`=0 and every requested wide beat has `beat_mask` = 0, including the ECC lane.
- R7: With ECC on, a write where any requested double word has a cleared byte enable sets `beat_rmw`=1 on every beat of its burst. Every beat then has all used lanes unmasked: 9'h000 on the wide bus, 9'h1E0 on the narrow bus.
- R8: Read bursts have `beat_rmw`=0, and every beat has all used lanes unmasked (9'h000 wide, 9'h1E0 narrow).
- R9: On the narrow bus `beat_mask[8:5]` is always 1 and `beat_mask[4]` is the ECC lane. For a requested write beat without read-modify-write, `beat_mask[3:0]` is the inverse of the four byte enables of the selected half.
- R10: While `beat_valid`=1 and `beat_ready`=0, all beat outputs hold their values into the next cycle.
- R11: `req_ready` is low from a legal acceptance until the cycle after the last beat's handshake. It is high again in that cycle, and no beat is valid then.
- R12: After reset `req_ready`=1, `beat_valid`=0 and `req_illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | log2(DW_PER_BURST) | Starting double-word offset |
| req_size | input | log2(DW_PER_BURST)+1 | Size in double words |
| req_be | input | 8*DW_PER_BURST | Byte enables, bits 8i..8i+7 for double word i |
| ecc_en | input | 1 | ECC enabled for this request |
| bus_wide | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Beat taken by the data path |
| beat_dw | output | log2(DW_PER_BURST) | Double-word index of the beat |
| beat_half | output | 1 | Upper half of the double word (narrow bus) |
| beat_mask | output | 9 | Lane mask, 1 = do not write; bit 8 (wide) or bit 4 (narrow) is the ECC lane |
| beat_last | output | 1 | Final beat of the burst |
| beat_rmw | output | 1 | Burst is the read phase of a read-modify-write |
| req_illegal | output | 1 | One-cycle pulse: rejected request |

## Verification
The bench sweeps every offset and every size code, including zero and oversize, against reads and writes, ECC on and off, and both bus widths. Each combination is run with three byte-enable patterns. A full-enable pattern separates the direct masked write from read-modify-write. A pattern that clears one byte in the first requested double word shows whether escalation looks at the requested range only. A pseudo-random pattern checks that the lane pass-through picks the right bytes and the right half. Randomised beat back-pressure checks that the order and masks survive stalls.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int DW_BYTES   = 8;
  localparam int MASK_W     = DW_BYTES + 1;
  localparam int HALF_BYTES = DW_BYTES / 2;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } seq_state_t;

  typedef struct packed {
    logic write;
    logic ecc;
    logic wide;
    logic rmw;
  } req_flags_t;
endpackage

// File: rtl/bb_req_check.sv
module bb_req_check
  import bb_pkg::*;
#(
  parameter int N = 4,
  localparam int OFF_W  = $clog2(N),
  localparam int SIZE_W = OFF_W + 1,
  localparam int BE_W   = N * DW_BYTES
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [SIZE_W-1:0] size,
  input  logic [BE_W-1:0]   be,
  input  logic              write,
  input  logic              ecc,
  output logic              legal,
  output logic              rmw
);
  logic [N-1:0] in_range;
  logic [N-1:0] partial;
  logic [SIZE_W:0] span_end;

  for (genvar i = 0; i < N; i++) begin : g_dw
    logic [OFF_W-1:0] rel;
    assign rel         = OFF_W'(i) - offset;
    assign in_range[i] = ({1'b0, rel} < size);
    assign partial[i]  = ~&be[i*DW_BYTES +: DW_BYTES];
  end

  assign span_end = {2'b00, offset} + {1'b0, size};
  assign legal    = (size != '0) && (span_end <= (SIZE_W+1)'(N));
  assign rmw      = write && ecc && |(in_range & partial);
endmodule

// File: rtl/bb_beat_seq.sv
module bb_beat_seq
  import bb_pkg::*;
#(
  parameter int N = 4,
  localparam int OFF_W  = $clog2(N),
  localparam int SIZE_W = OFF_W + 1,
  localparam int CNT_W  = OFF_W + 1,
  localparam int BE_W   = N * DW_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_legal,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [BE_W-1:0]   req_be,
  input  req_flags_t        req_flags,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic              beat_last,
  output logic [CNT_W-1:0]  cnt,
  output logic [OFF_W-1:0]  q_offset,
  output logic [SIZE_W-1:0] q_size,
  output logic [BE_W-1:0]   q_be,
  output req_flags_t        q_flags,
  output logic              illegal_pulse
);
  seq_state_t state;
  logic [CNT_W-1:0] final_cnt;

  assign final_cnt  = q_flags.wide ? CNT_W'(N - 1) : CNT_W'(2 * N - 1);
  assign req_ready  = (state == ST_IDLE);
  assign beat_valid = (state == ST_BURST);
  assign beat_last  = beat_valid && (cnt == final_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      q_offset      <= '0;
      q_size        <= '0;
      q_be          <= '0;
      q_flags       <= '0;
      illegal_pulse <= 1'b0;
    end else begin
      illegal_pulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_legal) begin
              q_offset <= req_offset;
              q_size   <= req_size;
              q_be     <= req_be;
              q_flags  <= req_flags;
              cnt      <= '0;
              state    <= ST_BURST;
            end else begin
              illegal_pulse <= 1'b1;
            end
          end
        end
        ST_BURST: begin
          if (beat_ready) begin
            if (cnt == final_cnt) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bb_lane_mask.sv
module bb_lane_mask
  import bb_pkg::*;
#(
  parameter int N = 4,
  localparam int OFF_W  = $clog2(N),
  localparam int SIZE_W = OFF_W + 1,
  localparam int CNT_W  = OFF_W + 1,
  localparam int BE_W   = N * DW_BYTES
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [OFF_W-1:0]  q_offset,
  input  logic [SIZE_W-1:0] q_size,
  input  logic [BE_W-1:0]   q_be,
  input  req_flags_t        q_flags,
  output logic [OFF_W-1:0]  dw,
  output logic              half,
  output logic [MASK_W-1:0] mask
);
  logic [DW_BYTES-1:0]   be_arr [N];
  logic [OFF_W-1:0]      pos;
  logic                  requested;
  logic [DW_BYTES-1:0]   be_dw;
  logic [DW_BYTES-1:0]   wide_lanes;
  logic [HALF_BYTES-1:0] narrow_lanes;
  logic                  ecc_lane;

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign be_arr[i] = q_be[i*DW_BYTES +: DW_BYTES];
  end

  assign pos       = q_flags.wide ? cnt[OFF_W-1:0] : cnt[CNT_W-1:1];
  assign dw        = q_offset + pos;
  assign half      = ~q_flags.wide & cnt[0];
  assign requested = ({1'b0, pos} < q_size);
  assign be_dw     = be_arr[dw];
  assign ecc_lane  = ~q_flags.ecc;

  for (genvar b = 0; b < DW_BYTES; b++) begin : g_wide_lane
    assign wide_lanes[b] = ~be_dw[b];
  end

  for (genvar b = 0; b < HALF_BYTES; b++) begin : g_narrow_lane
    assign narrow_lanes[b] = half ? ~be_dw[HALF_BYTES + b] : ~be_dw[b];
  end

  always_comb begin
    if (!q_flags.write || q_flags.rmw) begin
      mask = q_flags.wide ? '0 : {{(MASK_W-HALF_BYTES-1){1'b1}}, {(HALF_BYTES+1){1'b0}}};
    end else if (!requested) begin
      mask = '1;
    end else if (q_flags.wide) begin
      mask = {ecc_lane, wide_lanes};
    end else begin
      mask = {{(MASK_W-HALF_BYTES-1){1'b1}}, ecc_lane, narrow_lanes};
    end
  end
endmodule

// File: rtl/ddr_burst_shaper.sv
module ddr_burst_shaper
  import bb_pkg::*;
#(
  parameter int DW_PER_BURST = 4,
  localparam int OFF_W  = $clog2(DW_PER_BURST),
  localparam int SIZE_W = OFF_W + 1,
  localparam int CNT_W  = OFF_W + 1,
  localparam int BE_W   = DW_PER_BURST * DW_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [BE_W-1:0]   req_be,
  input  logic              ecc_en,
  input  logic              bus_wide,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [OFF_W-1:0]  beat_dw,
  output logic              beat_half,
  output logic [MASK_W-1:0] beat_mask,
  output logic              beat_last,
  output logic              beat_rmw,
  output logic              req_illegal
);
  logic              legal;
  logic              rmw_need;
  req_flags_t        in_flags;
  req_flags_t        q_flags;
  logic [CNT_W-1:0]  cnt;
  logic [OFF_W-1:0]  q_offset;
  logic [SIZE_W-1:0] q_size;
  logic [BE_W-1:0]   q_be;

  bb_req_check #(.N(DW_PER_BURST)) u_check (
    .offset (req_offset),
    .size   (req_size),
    .be     (req_be),
    .write  (req_write),
    .ecc    (ecc_en),
    .legal  (legal),
    .rmw    (rmw_need)
  );

  assign in_flags = '{write: req_write, ecc: ecc_en, wide: bus_wide, rmw: rmw_need};

  bb_beat_seq #(.N(DW_PER_BURST)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_legal     (legal),
    .req_offset    (req_offset),
    .req_size      (req_size),
    .req_be        (req_be),
    .req_flags     (in_flags),
    .beat_ready    (beat_ready),
    .beat_valid    (beat_valid),
    .beat_last     (beat_last),
    .cnt           (cnt),
    .q_offset      (q_offset),
    .q_size        (q_size),
    .q_be          (q_be),
    .q_flags       (q_flags),
    .illegal_pulse (req_illegal)
  );

  bb_lane_mask #(.N(DW_PER_BURST)) u_mask (
    .cnt      (cnt),
    .q_offset (q_offset),
    .q_size   (q_size),
    .q_be     (q_be),
    .q_flags  (q_flags),
    .dw       (beat_dw),
    .half     (beat_half),
    .mask     (beat_mask)
  );

  assign beat_rmw = beat_valid && q_flags.rmw;
endmodule

// File: rtl/bb_burst_checker.sv
module bb_burst_checker #(
  parameter int N = 4,
  localparam int OFF_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_offset,
  input logic             bus_wide,
  input logic             beat_valid,
  input logic             beat_ready,
  input logic [OFF_W-1:0] beat_dw,
  input logic             beat_half,
  input logic [8:0]       beat_mask,
  input logic             beat_last,
  input logic             beat_rmw,
  input logic             req_illegal
);
  logic [OFF_W-1:0] off_c;
  logic             wide_c;
  logic             first_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_c   <= '0;
      wide_c  <= 1'b1;
      first_c <= 1'b0;
    end else if (req_valid && req_ready) begin
      off_c   <= req_offset;
      wide_c  <= bus_wide;
      first_c <= 1'b1;
    end else if (beat_valid && beat_ready) begin
      first_c <= 1'b0;
    end
  end

  p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_dw) && $stable(beat_half)
      && $stable(beat_mask) && $stable(beat_last) && $stable(beat_rmw));

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> req_illegal || !req_ready);

  p_idle_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> req_ready && !beat_valid);

  p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_illegal |-> !beat_valid && req_ready);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && first_c |-> beat_dw == off_c && !beat_half);

  p_last_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_last |-> beat_dw == OFF_W'(off_c + OFF_W'(N - 1)) && (wide_c || beat_half));

  p_narrow_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !wide_c |-> &beat_mask[8:5]);

  p_rmw_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_rmw |-> beat_mask[4:0] == 5'b0);
endmodule

bind ddr_burst_shaper bb_burst_checker #(.N(DW_PER_BURST)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_offset  (req_offset),
  .bus_wide    (bus_wide),
  .beat_valid  (beat_valid),
  .beat_ready  (beat_ready),
  .beat_dw     (beat_dw),
  .beat_half   (beat_half),
  .beat_mask   (beat_mask),
  .beat_last   (beat_last),
  .beat_rmw    (beat_rmw),
  .req_illegal (req_illegal)
);

// File: tb/ddr_burst_shaper_tb.sv
module ddr_burst_shaper_tb;
  localparam int N     = 4;
  localparam int OFF_W = 2;
  localparam int SIZE_W = 3;
  localparam int BE_W  = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [OFF_W-1:0]  req_offset;
  logic [SIZE_W-1:0] req_size;
  logic [BE_W-1:0]   req_be;
  logic              ecc_en;
  logic              bus_wide;
  logic              beat_valid;
  logic              beat_ready;
  logic [OFF_W-1:0]  beat_dw;
  logic              beat_half;
  logic [8:0]        beat_mask;
  logic              beat_last;
  logic              beat_rmw;
  logic              req_illegal;

  ddr_burst_shaper #(.DW_PER_BURST(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_be(req_be), .ecc_en(ecc_en), .bus_wide(bus_wide),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_dw(beat_dw),
    .beat_half(beat_half), .beat_mask(beat_mask), .beat_last(beat_last),
    .beat_rmw(beat_rmw), .req_illegal(req_illegal)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  function automatic bit exp_rmw(int off, int size, bit wr, bit ecc, logic [31:0] be);
    bit r = 1'b0;
    if (!(wr && ecc)) return 1'b0;
    for (int p = 0; p < size; p++) begin
      if (be[((off + p) % N) * 8 +: 8] != 8'hFF) r = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [8:0] exp_mask(int off, int size, bit wr, bit ecc, bit wide,
                                          bit rmw, logic [31:0] be, int k);
    int pos = wide ? k : k / 2;
    int dw  = (off + pos) % N;
    int h   = wide ? 0 : k % 2;
    logic [7:0] b = be[dw * 8 +: 8];
    if (!wr || rmw) return wide ? 9'h000 : 9'h1E0;
    if (pos >= size) return 9'h1FF;
    if (wide) return {~ecc, ~b};
    return {4'hF, ~ecc, (h != 0) ? ~b[7:4] : ~b[3:0]};
  endfunction

  task automatic run_req(input int off, input int size, input bit wr, input bit ecc,
                         input bit wide, input logic [31:0] be);
    bit legal = (size >= 1) && (off + size <= N);
    bit rmw   = exp_rmw(off, size, wr, ecc, be);
    int nb    = wide ? N : 2 * N;
    int k     = 0;
    bit stalled = 1'b0;
    chk(req_ready == 1'b1, "R11 ready before request", 32'(req_ready), 32'd1);
    req_offset = OFF_W'(off);
    req_size   = SIZE_W'(size);
    req_write  = wr;
    ecc_en     = ecc;
    bus_wide   = wide;
    req_be     = be;
    req_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      chk(req_illegal == 1'b1, "R3 illegal pulse", 32'(req_illegal), 32'd1);
      chk(beat_valid == 1'b0, "R3 no beat", 32'(beat_valid), 32'd0);
      @(negedge clk);
      chk(req_illegal == 1'b0 && req_ready == 1'b1, "R3 pulse one cycle",
          {30'd0, req_illegal, req_ready}, 32'd1);
      return;
    end
    chk(req_illegal == 1'b0, "R3 legal no pulse", 32'(req_illegal), 32'd0);
    while (k < nb) begin
      int pos = wide ? k : k / 2;
      logic [8:0] em = exp_mask(off, size, wr, ecc, wide, rmw, be, k);
      string mtag;
      bit rdy;
      if (!wr) mtag = "R8 mask";
      else if (rmw) mtag = "R7 mask";
      else if (pos >= size) mtag = "R4 mask";
      else if (!wide) mtag = "R9 mask";
      else if (ecc) mtag = "R6 mask";
      else mtag = "R5 mask";
      chk(beat_valid == 1'b1, stalled ? "R10 valid held" : "R1 valid", 32'(beat_valid), 32'd1);
      chk(req_ready == 1'b0, "R11 busy", 32'(req_ready), 32'd0);
      chk(beat_dw == OFF_W'((off + pos) % N), stalled ? "R10 dw held" : "R2 dw",
          32'(beat_dw), 32'((off + pos) % N));
      chk(beat_half == (wide ? 1'b0 : 1'(k % 2)), "R2 half", 32'(beat_half), 32'(wide ? 0 : k % 2));
      chk(beat_mask == em, mtag, 32'(beat_mask), 32'(em));
      chk(beat_last == (k == nb - 1), "R1 last", 32'(beat_last), 32'(k == nb - 1));
      chk(beat_rmw == rmw, wr ? "R7 rmw flag" : "R8 rmw flag", 32'(beat_rmw), 32'(rmw));
      step_lfsr();
      rdy = (lfsr[1:0] != 2'b00);
      beat_ready = rdy;
      @(posedge clk);
      @(negedge clk);
      stalled = !rdy;
      if (rdy) k++;
    end
    beat_ready = 1'b0;
    chk(beat_valid == 1'b0 && req_ready == 1'b1, "R11 idle after last",
        {30'd0, beat_valid, req_ready}, 32'd1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1'b1;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_offset = '0; req_size = '0;
    req_be = '0; ecc_en = 1'b0; bus_wide = 1'b1; beat_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready == 1'b1, "R12 ready", 32'(req_ready), 32'd1);
    chk(beat_valid == 1'b0, "R12 no beat", 32'(beat_valid), 32'd0);
    chk(req_illegal == 1'b0, "R12 no illegal", 32'(req_illegal), 32'd0);
    for (int pat = 0; pat < 3; pat++) begin
      for (int wide = 0; wide < 2; wide++) begin
        for (int ecc = 0; ecc < 2; ecc++) begin
          for (int wr = 0; wr < 2; wr++) begin
            for (int off = 0; off < N; off++) begin
              for (int size = 0; size < 8; size++) begin
                logic [31:0] be;
                if (pat == 0) be = 32'hFFFF_FFFF;
                else if (pat == 1) begin
                  be = 32'hFFFF_FFFF;
                  be[off * 8 + (size % 8)] = 1'b0;
                end else begin
                  step_lfsr(); be[15:0] = lfsr;
                  step_lfsr(); be[31:16] = lfsr;
                end
                run_req(off, size, wr[0], ecc[0], wide[0], be);
              end
            end
          end
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule